// File: doc/BRIEF.md
# Dither Cycle Timing Sequencer

This block runs the digital timing of a line-drop correction loop. A fast oscillator clock is divided by a power-of-two ratio, picked by a 3-bit code, to make one dither period. Each period walks through a fixed measurement sequence. First the output voltage is regulated and the high-voltage and output-current samples are tracked. Then the loop switches to current regulation at a reduced level and the low-voltage sample is tracked. Finally a one-clock strobe captures the voltage delta. That delta becomes the correction used during the following period. The analog track/hold stages are driven by the phase outputs and are not modelled here.

A spread option moves the two internal phase boundaries by small pseudo-random amounts on each period. This breaks up beat notes against load or converter activity. A small supervisor holds everything idle until the run input is high and the overvoltage input is low. It also produces an 8-bit soft-correct weight that starts at zero (no wiring correction) and climbs one step per completed period. Overvoltage or loss of run clears that weight so the ramp starts over.

Top module: `dither_seq`

## Requirements
- R1: The dither period is 2^(div+3) clocks, so div codes 0 to 7 give 8, 16, 32, 64, 128, 256, 512 and 1024 clocks between consecutive cycle_done pulses.
- R2: While running, exactly one of reg_hi, trk_hi, reg_lo and trk_lo is high in each clock. Each period visits them in that order and begins with reg_hi. delta_cap and cycle_done are high together for only the last clock of the period, which falls in trk_lo.
- R3: With spread low, reg_hi and reg_lo each last 3/8 of the period and trk_hi and trk_lo each last 1/8 of the period.
- R4: mode is 1 (current loop commanding 90% of the tracked current) during reg_lo and trk_lo, and 0 (voltage loop) during reg_hi and trk_hi.
- R5: With spread high, the reg_hi/trk_hi and reg_lo/trk_lo boundaries move by at most 1/32 of the period from their fixed positions. The mid-period boundary stays exactly at half the period. The offsets are drawn from a 7-bit maximal-length shift register (x^7+x^6+1) that steps once per period, so the boundaries vary from one period to the next.
- R6: delta_cap is asserted on the last clock of every period, so the captured delta is available as the correction for the following period.
- R7: Changes to div and spread take effect only at a period boundary. The period in progress keeps its length.
- R8: While run_ok is low or ov is high, all phase outputs, mode and cycle_done are 0 and corr_weight is 0.
- R9: corr_weight rises by one on each completed period and saturates at 255.
- R10: Asserting ov, even in the clock where a period completes, clears corr_weight to 0 on the next edge. After ov clears, a new period starts from reg_hi with the weight ramp beginning at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div | input | 3 | Division ratio code |
| spread | input | 1 | Enables pseudo-random boundary offsets |
| run_ok | input | 1 | Supply above start-up threshold |
| ov | input | 1 | Overvoltage condition |
| reg_hi | output | 1 | Voltage regulation phase |
| trk_hi | output | 1 | Track high voltage and output current |
| reg_lo | output | 1 | Current regulation at reduced level |
| trk_lo | output | 1 | Track low voltage |
| delta_cap | output | 1 | Capture voltage delta for the next period |
| mode | output | 1 | 1 = current loop, 0 = voltage loop |
| cycle_done | output | 1 | One-clock end-of-period pulse |
| corr_weight | output | 8 | Soft-correct ramp weight |

## Verification
Two functions can fall in the same clock: the end-of-period weight increment, and the overvoltage clear of that weight. The bench raises ov at the sample where cycle_done is visible. It then expects the weight to read 0 rather than one more than before, and the phases to be idle. It expects a fresh period from reg_hi after release. A second collision is a div change in the middle of a period, which must leave the current length intact and apply only to the next period.

// File: rtl/dither_seq.sv
module dither_seq #(
  parameter int CODE_W     = 3,
  parameter int BASE_SHIFT = 3,
  parameter int WEIGHT_W   = 8,
  parameter int LFSR_W     = 7,
  parameter int JIT_W      = 6,
  parameter int LFSR_SEED  = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   div,
  input  logic                spread,
  input  logic                run_ok,
  input  logic                ov,
  output logic                reg_hi,
  output logic                trk_hi,
  output logic                reg_lo,
  output logic                trk_lo,
  output logic                delta_cap,
  output logic                mode,
  output logic                cycle_done,
  output logic [WEIGHT_W-1:0] corr_weight
);
  localparam int CNT_W = BASE_SHIFT + (1 << CODE_W) - 1;
  localparam int SW    = CNT_W + 2;

  logic                go, run_q, spr_q, last;
  logic [CODE_W-1:0]   code_q;
  logic [CNT_W-1:0]    cnt;
  logic [LFSR_W-1:0]   lfsr;
  logic [WEIGHT_W-1:0] weight;
  logic [CNT_W:0]      per, half, base, jmax, b_hi, b_lo, cx;
  logic signed [SW-1:0] lim, raw1, raw2, off1, off2;

  function automatic logic signed [SW-1:0] clampj(input logic signed [SW-1:0] r,
                                                  input logic signed [SW-1:0] l);
    return (r > l) ? l : ((r < -l) ? -l : r);
  endfunction

  assign go   = run_ok & ~ov;
  assign per  = (CNT_W+1)'(1) << (int'(code_q) + BASE_SHIFT);
  assign half = per >> 1;
  assign base = half - (half >> 2);
  assign jmax = spr_q ? (half >> 4) : '0;
  assign lim  = $signed({1'b0, jmax});
  assign raw1 = SW'($signed(lfsr[JIT_W-1:0]));
  assign raw2 = SW'($signed({lfsr[0], lfsr[LFSR_W-1:LFSR_W-JIT_W+1]}));
  assign off1 = clampj(raw1, lim);
  assign off2 = clampj(raw2, lim);
  assign b_hi = (CNT_W+1)'($signed({1'b0, base}) + off1);
  assign b_lo = half + (CNT_W+1)'($signed({1'b0, base}) + off2);
  assign cx   = {1'b0, cnt};
  assign last = run_q && (cx == per - 1'b1);

  assign reg_hi      = run_q && (cx < b_hi);
  assign trk_hi      = run_q && (cx >= b_hi) && (cx < half);
  assign reg_lo      = run_q && (cx >= half) && (cx < b_lo);
  assign trk_lo      = run_q && (cx >= b_lo);
  assign mode        = reg_lo | trk_lo;
  assign delta_cap   = last & trk_lo;
  assign cycle_done  = last;
  assign corr_weight = weight;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt    <= '0;
      code_q <= '0;
      spr_q  <= 1'b0;
      lfsr   <= LFSR_W'(LFSR_SEED);
      weight <= '0;
    end else begin
      run_q <= go;
      if (!go) begin
        cnt    <= '0;
        weight <= '0;
        code_q <= div;
        spr_q  <= spread;
      end else if (run_q) begin
        if (last) begin
          cnt    <= '0;
          code_q <= div;
          spr_q  <= spread;
          lfsr   <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_W-2]};
          if (weight != '1) weight <= weight + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> $onehot({reg_hi, trk_hi, reg_lo, trk_lo}));
  // R2
  wrap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && go |=> reg_hi);
  // R2
  trk_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trk_lo && go && !cycle_done |=> trk_lo);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && go && !cycle_done |=> $stable(code_q) && $stable(spr_q));
  // R9
  weight_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done && go && corr_weight != '1 |=> corr_weight == $past(corr_weight) + 1'b1);
  // R9
  weight_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go && !cycle_done |=> $stable(corr_weight));
  // R10
  ov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov |=> corr_weight == '0 && !reg_hi && !trk_hi && !reg_lo && !trk_lo);
endmodule

// File: tb/dither_seq_bench.sv
module dither_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] div = '0;
  logic spread = 1'b0, run_ok = 1'b0, ov = 1'b0;
  logic reg_hi, trk_hi, reg_lo, trk_lo, delta_cap, mode, cycle_done;
  logic [7:0] corr_weight;
  int nerr = 0, nchk = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dither_seq u_dither_seq (
    .clk(clk), .rst_n(rst_n), .div(div), .spread(spread), .run_ok(run_ok), .ov(ov),
    .reg_hi(reg_hi), .trk_hi(trk_hi), .reg_lo(reg_lo), .trk_lo(trk_lo),
    .delta_cap(delta_cap), .mode(mode), .cycle_done(cycle_done), .corr_weight(corr_weight));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic bit all_idle();
    return !reg_hi && !trk_hi && !reg_lo && !trk_lo && !mode && !cycle_done && !delta_cap;
  endfunction

  // Starts at the first clock of a period, returns at the first clock of the next.
  task automatic measure(output int rh, output int th, output int rl, output int tl,
                         input int chg_at, input logic [2:0] chg_div);
    int prev = 0, steps = 0, bad_oh = 0, bad_ord = 0, bad_mode = 0, bad_end = 0;
    bit done = 1'b0;
    rh = 0; th = 0; rl = 0; tl = 0;
    chk(reg_hi, "R2 period opens with reg_hi", int'(reg_hi), 1);
    while (!done && steps < 5000) begin
      int idx;
      int n;
      n = int'(reg_hi) + int'(trk_hi) + int'(reg_lo) + int'(trk_lo);
      idx = reg_hi ? 0 : trk_hi ? 1 : reg_lo ? 2 : 3;
      if (n != 1) bad_oh++;
      if (idx < prev) bad_ord++;
      if (mode != (idx >= 2)) bad_mode++;
      prev = idx;
      case (idx)
        0: rh++;
        1: th++;
        2: rl++;
        default: tl++;
      endcase
      if (delta_cap != cycle_done) bad_end++;
      if (cycle_done) begin
        done = 1'b1;
        if (idx != 3) bad_end++;
      end
      if (steps == chg_at) div = chg_div;
      tick();
      steps++;
    end
    chk(bad_oh == 0, "R2 one-hot phases", bad_oh, 0);
    chk(bad_ord == 0, "R2 phase order", bad_ord, 0);
    chk(bad_mode == 0, "R4 mode follows loop type", bad_mode, 0);
    chk(bad_end == 0, "R6 delta_cap on last clock", bad_end, 0);
  endtask

  task automatic start(input logic [2:0] code, input logic spr);
    run_ok = 1'b0; ov = 1'b0;
    tick();
    div = code; spread = spr;
    tick();
    run_ok = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    run_ok = 1'b1;
    repeat (3) tick();
    chk(all_idle() && corr_weight == 0, "R8 reset state", int'(corr_weight), 0);
    rst_n = 1'b1;
    run_ok = 1'b0;
    repeat (10) tick();
    chk(all_idle() && corr_weight == 0, "R8 idle with run_ok low", int'(corr_weight), 0);
    run_ok = 1'b1; ov = 1'b1;
    repeat (10) tick();
    chk(all_idle() && corr_weight == 0, "R8 idle with ov high", int'(corr_weight), 0);
    ov = 1'b0;
  endtask

  task automatic t_ratio();
    for (int c = 0; c < 8; c++) begin
      int rh, th, rl, tl, p;
      p = 1 << (c + 3);
      start(3'(c), 1'b0);
      chk(corr_weight == 0, "R10 ramp starts at zero", int'(corr_weight), 0);
      measure(rh, th, rl, tl, -1, 3'(c));
      chk(rh + th + rl + tl == p, "R1 period length", rh + th + rl + tl, p);
      chk(rh == 3 * p / 8 && rl == 3 * p / 8, "R3 regulate lengths", rh * 10000 + rl, (3*p/8) * 10001);
      chk(th == p / 8 && tl == p / 8, "R3 track lengths", th * 10000 + tl, (p/8) * 10001);
      chk(corr_weight == 1, "R9 weight after first period", int'(corr_weight), 1);
    end
  endtask

  task automatic t_sample();
    int rh, th, rl, tl;
    start(3'd0, 1'b0);
    measure(rh, th, rl, tl, 2, 3'd2);
    chk(rh + th + rl + tl == 8, "R7 current period keeps length", rh + th + rl + tl, 8);
    measure(rh, th, rl, tl, 5, 3'd2);
    chk(rh + th + rl + tl == 32, "R7 new ratio at boundary", rh + th + rl + tl, 32);
    spread = 1'b1;
    measure(rh, th, rl, tl, -1, 3'd2);
    chk(rh == 12 && rl == 12, "R7 spread change waits for boundary", rh * 100 + rl, 1212);
    spread = 1'b0;
  endtask

  task automatic t_spread();
    int first = -1, bad_bound = 0, bad_half = 0, varied = 0;
    start(3'd7, 1'b1);
    for (int k = 0; k < 12; k++) begin
      int rh, th, rl, tl;
      measure(rh, th, rl, tl, -1, 3'd7);
      if (rh < 352 || rh > 416 || rl < 352 || rl > 416) bad_bound++;
      if (rh + th != 512 || rl + tl != 512) bad_half++;
      if (first < 0) first = rh;
      else if (rh != first) varied = 1;
    end
    chk(bad_bound == 0, "R5 jitter within 1/32 period", bad_bound, 0);
    chk(bad_half == 0, "R5 mid boundary fixed", bad_half, 0);
    chk(varied == 1, "R5 boundaries vary per period", varied, 1);
  endtask

  task automatic t_sat();
    int bad = 0;
    start(3'd0, 1'b0);
    for (int k = 1; k <= 260; k++) begin
      int rh, th, rl, tl;
      measure(rh, th, rl, tl, -1, 3'd0);
      if (corr_weight != 8'((k > 255) ? 255 : k)) bad++;
    end
    chk(bad == 0, "R9 per-period step", bad, 0);
    chk(corr_weight == 255, "R9 saturation", int'(corr_weight), 255);
  endtask

  task automatic t_ov_mid();
    int rh, th, rl, tl;
    start(3'd1, 1'b0);
    measure(rh, th, rl, tl, -1, 3'd1);
    repeat (5) tick();
    ov = 1'b1;
    tick();
    chk(all_idle() && corr_weight == 0, "R10 ov mid-period clears", int'(corr_weight), 0);
    repeat (4) tick();
    ov = 1'b0;
    tick();
    measure(rh, th, rl, tl, -1, 3'd1);
    chk(rh + th + rl + tl == 16, "R10 fresh period after ov", rh + th + rl + tl, 16);
    chk(corr_weight == 1, "R10 ramp restarts", int'(corr_weight), 1);
  endtask

  task automatic t_ov_coincide();
    int rh, th, rl, tl, guard = 0;
    start(3'd0, 1'b0);
    measure(rh, th, rl, tl, -1, 3'd0);
    measure(rh, th, rl, tl, -1, 3'd0);
    while (!cycle_done && guard < 50) begin
      tick();
      guard++;
    end
    chk(corr_weight == 2, "R9 weight before collision", int'(corr_weight), 2);
    ov = 1'b1;
    tick();
    chk(corr_weight == 0, "R10 ov wins over increment", int'(corr_weight), 0);
    chk(all_idle(), "R8 idle after ov", int'(reg_hi), 0);
    ov = 1'b0;
    tick();
    chk(reg_hi && corr_weight == 0, "R10 restart from reg_hi", int'(reg_hi), 1);
    run_ok = 1'b0;
    tick();
    chk(all_idle() && corr_weight == 0, "R8 run_ok low clears", int'(corr_weight), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    tick();
    t_reset();
    t_ratio();
    t_sample();
    t_spread();
    t_sat();
    t_ov_mid();
    t_ov_coincide();
    finish_run();
  end
endmodule